// File: doc/BRIEF.md
# Banked Direct-Mapped Data Cache

This block is a word-addressed, direct-mapped first-level data cache that several requesting thread ports share. The cache words are spread across a configurable number of banks. Each cycle, every bank serves at most one port, and any other port that wants that bank is told to retry. Loads that hit return their word one cycle after they are accepted. Stores write through to the next level and never allocate a line. When a load misses, a line fill from the next level is started. While that one fill is outstanding, hits from any port are still served and are counted as hits under miss.

A fill starts with a line request handshake, `fill_req_valid` / `fill_req_ready`, which carries the line address. The next level then returns the line one word per `fill_rsp_valid` beat, lowest word first. A small state machine runs the fill through three states:
- **F_IDLE** goes to **F_ASK** on *start*, when a bank-winning load misses.
- **F_ASK** goes to **F_RECV** on *granted*, when `fill_req_ready` is high.
- **F_RECV** goes back to **F_IDLE** on *last beat*, when the final word arrives. On that beat the tag and valid bit of the line are written.

Six counters record activity on the ports.

Top module: `dcb_cache`

## Requirements
- R1: A synchronous reset clears every line valid bit and all six statistics counters. It also leaves `fill_req_valid` and every `rsp_valid` low.
- R2: The bank of a request is `addr[log2(NBANK)-1:0]`. When several valid requests target one bank in a cycle, only the lowest-numbered port may be accepted. Each other port has `req_ready` low in that cycle and adds one to the conflict counter.
- R3: A load that wins its bank and hits is accepted in that cycle (`req_ready` high). In the next cycle `rsp_valid` is high and `rsp_rdata` holds the word.
- R4: A load that wins its bank and misses is not accepted. If no fill is in progress, the block requests line `addr >> LINE_LOG2`, writes the returned beats at word offsets 0 upward, and marks the line valid on the last beat. The retried load then hits.
- R5: Only one fill is outstanding at a time. Other misses stall without being counted, and the miss counter rises by one per fill started.
- R6: A load hit accepted while a fill is outstanding is served normally. It counts in the hit-under-miss counter and not in the hit counter.
- R7: A store that wins its bank is accepted in that cycle and appears in the same cycle on `wr_valid`/`wr_addr`/`wr_data`. On a hit it updates the cached word. On a miss it allocates nothing, so no fill is requested. Each accepted store adds one to the store counter.
- R8: The line index is `addr[LINE_LOG2+IB-1:LINE_LOG2]` and the tag is the remaining upper bits. Filling a line with a different tag at the same index evicts the previous line.
- R9: The access counter adds one for every accepted request, load or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORT | Request present, one bit per port |
| req_we | input | NPORT | 1 = store, 0 = load |
| req_addr | input | NPORT*AW | Word address per port |
| req_wdata | input | NPORT*DW | Store data per port |
| req_ready | output | NPORT | Request accepted this cycle |
| rsp_valid | output | NPORT | Load data valid (one cycle after acceptance) |
| rsp_rdata | output | NPORT*DW | Load data per port |
| fill_req_valid | output | 1 | Line fill requested |
| fill_req_ready | input | 1 | Next level takes the fill request |
| fill_req_line | output | AW-LINE_LOG2 | Line address being fetched |
| fill_rsp_valid | input | 1 | One fill word present |
| fill_rsp_data | input | DW | Fill word |
| wr_valid | output | NPORT | Store forwarded to next level |
| wr_addr | output | NPORT*AW | Forwarded store address |
| wr_data | output | NPORT*DW | Forwarded store data |
| stat_access | output | CW | Accepted requests |
| stat_hit | output | CW | Load hits with no fill outstanding |
| stat_miss | output | CW | Fills started |
| stat_conflict | output | CW | Port-cycles lost to bank arbitration |
| stat_store | output | CW | Accepted stores |
| stat_hum | output | CW | Load hits during an outstanding fill |

## Verification
Single-port load sequences separate a cold miss, an immediate hit, and an eviction by a same-index, different-tag address. Each of these shows up as a different number of fill requests and stall cycles. Two ports driven in the same cycle compare same-bank pairs, which must serialize and count a conflict, with different-bank pairs, which must both be accepted at once. A port that hits while another port's miss is being filled checks the hit-under-miss path. A second miss during that fill checks that it stalls and is counted only once. Store hits and store misses are followed by loads of the same word: the load data and the fill count show whether the word was updated and whether a line was allocated.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_ASK  = 2'd1,
        F_RECV = 2'd2
    } fill_state_t;
endpackage

// File: rtl/dcb_bank_arb.sv
module dcb_bank_arb #(
    parameter int NPORT = 2,
    parameter int NBANK = 4,
    localparam int BB   = $clog2(NBANK)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORT-1:0]    valid,
    input  logic [NPORT*BB-1:0] bank_sel,
    output logic [NPORT-1:0]    win,
    output logic [NPORT-1:0]    lose
);
    // Fixed priority per bank: a lower port index beats a higher one.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            win[p] = valid[p];
            for (int q = 0; q < p; q++) begin
                if (valid[q] && (bank_sel[q*BB +: BB] == bank_sel[p*BB +: BB]))
                    win[p] = 1'b0;
            end
            lose[p] = valid[p] && !win[p];
        end
    end

    genvar gb, gp;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_bank_chk
            logic [NPORT-1:0] granted;
            for (gp = 0; gp < NPORT; gp++) begin : g_port
                assign granted[gp] = win[gp] && (bank_sel[gp*BB +: BB] == BB'(gb));
            end
            // R2: no bank serves two ports in one cycle
            p_one_grant_per_bank_r2: assert property (@(posedge clk) disable iff (rst)
                $onehot0(granted));
        end
    endgenerate
endmodule

// File: rtl/dcb_fill_fsm.sv
module dcb_fill_fsm
    import dcb_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LINE_LOG2 = 4,
    localparam int LAW      = AW - LINE_LOG2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [LAW-1:0]       start_line,
    input  logic                 fill_req_ready,
    input  logic                 fill_rsp_valid,
    output logic                 busy,
    output logic                 fill_req_valid,
    output logic [LAW-1:0]       fill_line,
    output logic                 beat_we,
    output logic [LINE_LOG2-1:0] beat_off,
    output logic                 fill_done
);
    fill_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            F_IDLE: if (start)          nxt = F_ASK;
            F_ASK:  if (fill_req_ready) nxt = F_RECV;
            F_RECV: if (fill_rsp_valid && beat_off == LINE_LOG2'((1 << LINE_LOG2) - 1))
                                        nxt = F_IDLE;
            default:                    nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= F_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        busy           = (state != F_IDLE);
        fill_req_valid = (state == F_ASK);
        beat_we        = (state == F_RECV) && fill_rsp_valid;
        fill_done      = beat_we && (beat_off == LINE_LOG2'((1 << LINE_LOG2) - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_line <= '0;
            beat_off  <= '0;
        end else begin
            if (state == F_IDLE && start) begin
                fill_line <= start_line;
                beat_off  <= '0;
            end else if (beat_we) begin
                beat_off  <= beat_off + 1'b1;
            end
        end
    end

    // R5: the fill request and its line address hold until the next level takes it
    p_fill_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable(fill_line));
endmodule

// File: rtl/dcb_stats.sv
module dcb_stats #(
    parameter int NPORT = 2,
    parameter int CW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] acc,
    input  logic [NPORT-1:0] hit,
    input  logic [NPORT-1:0] hum,
    input  logic [NPORT-1:0] st,
    input  logic [NPORT-1:0] lose,
    input  logic             miss_start,
    output logic [CW-1:0]    stat_access,
    output logic [CW-1:0]    stat_hit,
    output logic [CW-1:0]    stat_miss,
    output logic [CW-1:0]    stat_conflict,
    output logic [CW-1:0]    stat_store,
    output logic [CW-1:0]    stat_hum
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_access   <= '0;
            stat_hit      <= '0;
            stat_miss     <= '0;
            stat_conflict <= '0;
            stat_store    <= '0;
            stat_hum      <= '0;
        end else begin
            stat_access   <= stat_access   + CW'($countones(acc));
            stat_hit      <= stat_hit      + CW'($countones(hit));
            stat_hum      <= stat_hum      + CW'($countones(hum));
            stat_store    <= stat_store    + CW'($countones(st));
            stat_conflict <= stat_conflict + CW'($countones(lose));
            stat_miss     <= stat_miss     + CW'(miss_start);
        end
    end
endmodule

// File: rtl/dcb_cache.sv
module dcb_cache #(
    parameter int NPORT     = 2,
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int CAP_WORDS = 2048,
    parameter int LINE_LOG2 = 4,
    parameter int NBANK     = 4,
    parameter int CW        = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        req_valid,
    input  logic [NPORT-1:0]        req_we,
    input  logic [NPORT*AW-1:0]     req_addr,
    input  logic [NPORT*DW-1:0]     req_wdata,
    output logic [NPORT-1:0]        req_ready,
    output logic [NPORT-1:0]        rsp_valid,
    output logic [NPORT*DW-1:0]     rsp_rdata,
    output logic                    fill_req_valid,
    input  logic                    fill_req_ready,
    output logic [AW-LINE_LOG2-1:0] fill_req_line,
    input  logic                    fill_rsp_valid,
    input  logic [DW-1:0]           fill_rsp_data,
    output logic [NPORT-1:0]        wr_valid,
    output logic [NPORT*AW-1:0]     wr_addr,
    output logic [NPORT*DW-1:0]     wr_data,
    output logic [CW-1:0]           stat_access,
    output logic [CW-1:0]           stat_hit,
    output logic [CW-1:0]           stat_miss,
    output logic [CW-1:0]           stat_conflict,
    output logic [CW-1:0]           stat_store,
    output logic [CW-1:0]           stat_hum
);
    localparam int LW     = 1 << LINE_LOG2;
    localparam int NLINES = CAP_WORDS / LW;
    localparam int IB     = $clog2(NLINES);
    localparam int BB     = $clog2(NBANK);
    localparam int TB     = AW - LINE_LOG2 - IB;
    localparam int WB     = LINE_LOG2 + IB;
    localparam int LAW    = AW - LINE_LOG2;

    logic [DW-1:0]       data_mem [CAP_WORDS];
    logic [TB-1:0]       tag_mem  [NLINES];
    logic [NLINES-1:0]   line_vld;

    logic [NPORT*BB-1:0] bank_sel;
    logic [NPORT-1:0]    win, lose, hit_v;
    logic [NPORT-1:0]    ld_hit, ld_miss, st_acc;
    logic                fill_busy, fill_start, start_found;
    logic [LAW-1:0]      start_line, fill_line;
    logic                beat_we, fill_done;
    logic [LINE_LOG2-1:0] beat_off;

    genvar gp;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_port
            logic [AW-1:0] pa;
            logic [IB-1:0] pidx;
            assign pa    = req_addr[gp*AW +: AW];
            assign pidx  = pa[LINE_LOG2 +: IB];
            assign bank_sel[gp*BB +: BB] = pa[BB-1:0];
            assign hit_v[gp]   = line_vld[pidx] && (tag_mem[pidx] == pa[AW-1 -: TB]);
            assign ld_hit[gp]  = win[gp] && !req_we[gp] &&  hit_v[gp];
            assign ld_miss[gp] = win[gp] && !req_we[gp] && !hit_v[gp];
            assign st_acc[gp]  = win[gp] &&  req_we[gp];
            // R2: a port that lost its bank is never accepted in that cycle
            p_lose_stalls_r2: assert property (@(posedge clk) disable iff (rst)
                lose[gp] |-> !req_ready[gp]);
        end
    endgenerate

    assign req_ready = ld_hit | st_acc;
    assign wr_valid  = st_acc;
    assign wr_addr   = req_addr;
    assign wr_data   = req_wdata;

    dcb_bank_arb #(.NPORT(NPORT), .NBANK(NBANK)) u_arb (
        .clk(clk), .rst(rst), .valid(req_valid), .bank_sel(bank_sel),
        .win(win), .lose(lose)
    );

    // The lowest-numbered missing port gets the fill.
    always_comb begin
        start_found = 1'b0;
        start_line  = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (!start_found && ld_miss[p]) begin
                start_found = 1'b1;
                start_line  = req_addr[p*AW + LINE_LOG2 +: LAW];
            end
        end
    end
    assign fill_start    = start_found && !fill_busy;
    assign fill_req_line = fill_line;

    dcb_fill_fsm #(.AW(AW), .LINE_LOG2(LINE_LOG2)) u_fill (
        .clk(clk), .rst(rst), .start(fill_start), .start_line(start_line),
        .fill_req_ready(fill_req_ready), .fill_rsp_valid(fill_rsp_valid),
        .busy(fill_busy), .fill_req_valid(fill_req_valid), .fill_line(fill_line),
        .beat_we(beat_we), .beat_off(beat_off), .fill_done(fill_done)
    );

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (st_acc[p] && hit_v[p])
                data_mem[req_addr[p*AW +: WB]] <= req_wdata[p*DW +: DW];
            rsp_rdata[p*DW +: DW] <= data_mem[req_addr[p*AW +: WB]];
        end
        if (beat_we)
            data_mem[{fill_line[IB-1:0], beat_off}] <= fill_rsp_data;
        if (fill_done)
            tag_mem[fill_line[IB-1:0]] <= fill_line[LAW-1 -: TB];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_vld  <= '0;
            rsp_valid <= '0;
        end else begin
            rsp_valid <= ld_hit;
            if (fill_start) line_vld[start_line[IB-1:0]] <= 1'b0;
            if (fill_done)  line_vld[fill_line[IB-1:0]]  <= 1'b1;
        end
    end

    dcb_stats #(.NPORT(NPORT), .CW(CW)) u_stats (
        .clk(clk), .rst(rst), .acc(req_ready),
        .hit(ld_hit & {NPORT{!fill_busy}}), .hum(ld_hit & {NPORT{fill_busy}}),
        .st(st_acc), .lose(lose), .miss_start(fill_start),
        .stat_access(stat_access), .stat_hit(stat_hit), .stat_miss(stat_miss),
        .stat_conflict(stat_conflict), .stat_store(stat_store), .stat_hum(stat_hum)
    );

    // R5: no further miss is counted while a fill is outstanding
    p_miss_quiet_busy_r5: assert property (@(posedge clk) disable iff (rst)
        fill_busy |=> $stable(stat_miss));
    // R6: the hit-under-miss counter moves only while a fill is outstanding
    p_hum_needs_fill_r6: assert property (@(posedge clk) disable iff (rst)
        !fill_busy |=> $stable(stat_hum));
    // R7: a forwarded store is always one a port actually issued
    p_store_fwd_r7: assert property (@(posedge clk) disable iff (rst)
        |wr_valid |-> |(req_valid & req_we));
endmodule

// File: tb/dcb_cache_test.sv
module dcb_cache_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  req_valid, req_we, req_ready, rsp_valid, wr_valid;
    logic [31:0] req_addr, wr_addr;
    logic [63:0] req_wdata, rsp_rdata, wr_data;
    logic        fill_req_valid, fill_req_ready, fill_rsp_valid;
    logic [11:0] fill_req_line;
    logic [31:0] fill_rsp_data;
    logic [31:0] stat_access, stat_hit, stat_miss, stat_conflict, stat_store, stat_hum;

    int checks = 0, failures = 0, acc_model = 0, fills_seen = 0;
    logic [11:0] last_line;
    bit done_flag = 0;
    logic [31:0] bk [int];
    logic [31:0] exp_q0 [$];
    logic [31:0] exp_q1 [$];

    always #2.5 clk = ~clk;

    dcb_cache uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
        .fill_req_line(fill_req_line), .fill_rsp_valid(fill_rsp_valid),
        .fill_rsp_data(fill_rsp_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .stat_access(stat_access), .stat_hit(stat_hit),
        .stat_miss(stat_miss), .stat_conflict(stat_conflict),
        .stat_store(stat_store), .stat_hum(stat_hum)
    );

    function automatic logic [31:0] backing(input logic [15:0] a);
        if (bk.exists(int'(a))) return bk[int'(a)];
        return {a ^ 16'h5A5A, a};
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic push(input int p, input logic [31:0] v);
        if (p == 0) exp_q0.push_back(v);
        else        exp_q1.push_back(v);
    endtask

    // Next level: accepts the request, waits, then streams the line in order (R4)
    initial begin
        fill_req_ready = 0; fill_rsp_valid = 0; fill_rsp_data = '0; last_line = '0;
        forever begin
            @(negedge clk);
            if (fill_req_valid) begin
                last_line = fill_req_line;
                fills_seen++;
                fill_req_ready = 1;
                @(negedge clk);
                fill_req_ready = 0;
                repeat (3) @(negedge clk);
                for (int k = 0; k < 16; k++) begin
                    fill_rsp_valid = 1;
                    fill_rsp_data  = backing({last_line, 4'(k)});
                    @(negedge clk);
                end
                fill_rsp_valid = 0;
            end
        end
    end

    // Monitor: pops the scoreboard as responses appear (R3)
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (rsp_valid[0]) begin
                if (exp_q0.size() == 0) chk("R3 unexpected response port0", 1, 0);
                else chk("R3 load data port0", rsp_rdata[31:0], exp_q0.pop_front());
            end
            if (rsp_valid[1]) begin
                if (exp_q1.size() == 0) chk("R3 unexpected response port1", 1, 0);
                else chk("R3 load data port1", rsp_rdata[63:32], exp_q1.pop_front());
            end
        end
    end

    task automatic issue(input int p, input bit we, input logic [15:0] a,
                         input logic [31:0] d, output int waited);
        waited = 0;
        @(negedge clk);
        req_valid[p] = 1; req_we[p] = we;
        req_addr[p*16 +: 16] = a; req_wdata[p*32 +: 32] = d;
        forever begin
            #1;
            if (req_ready[p]) break;
            @(negedge clk);
            waited++;
        end
        acc_model++;
        if (we) begin
            chk("R7 store forwarded", {wr_valid[p], wr_addr[p*16 +: 16], wr_data[p*32 +: 32]},
                {1'b1, a, d});
            bk[int'(a)] = d;
        end else begin
            push(p, backing(a));
        end
        @(negedge clk);
        req_valid[p] = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int w0, w1, f0, h0, m0;
        req_valid = '0; req_we = '0; req_addr = '0; req_wdata = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 counters after reset", {stat_access, stat_hit, stat_miss, stat_conflict,
            stat_store, stat_hum}, '0);
        chk("R1 outputs after reset", {rsp_valid, fill_req_valid}, '0);
        rst = 0;

        // R4: cold miss fetches line 0x004, retry then hits
        issue(0, 0, 16'h0040, 0, w0);
        chk("R4 miss stalled", w0 > 20, 1);
        chk("R4 fill line address", {fills_seen, last_line}, {32'd1, 12'h004});
        chk("R5 one miss counted", stat_miss, 1);

        // R3: hit accepted at once, response next cycle
        issue(0, 0, 16'h0041, 0, w0);
        chk("R3 hit not stalled", w0, 0);
        #2;
        chk("R3 response one cycle later", rsp_valid[0], 1);

        // R2: same bank (bank 2) from both ports in one cycle
        @(negedge clk);
        req_valid = 2'b11; req_we = 2'b00; req_addr = {16'h0046, 16'h0042};
        #1;
        chk("R2 lower port wins bank", req_ready, 2'b01);
        push(0, backing(16'h0042)); acc_model++;
        @(negedge clk);
        req_valid[0] = 0;
        #1;
        chk("R2 loser served next cycle", req_ready[1], 1);
        push(1, backing(16'h0046)); acc_model++;
        @(negedge clk);
        req_valid[1] = 0;
        #1;
        chk("R2 conflict counted", stat_conflict, 1);

        // R2: different banks are served together
        fork
            issue(0, 0, 16'h0043, 0, w0);
            issue(1, 0, 16'h0044, 0, w1);
        join
        chk("R2 different banks both accepted", {w0, w1}, '0);

        // R7: store hit updates cached word
        issue(1, 1, 16'h0045, 32'hDEADBEEF, w1);
        issue(0, 0, 16'h0045, 0, w0);
        chk("R7 store counted", stat_store, 1);

        // R7: store miss allocates nothing
        f0 = fills_seen; m0 = stat_miss;
        issue(0, 1, 16'h0100, 32'h12345678, w0);
        repeat (4) @(negedge clk);
        chk("R7 store miss no fill", {fills_seen, stat_miss}, {f0, m0});
        issue(0, 0, 16'h0100, 0, w0);
        chk("R7 load after store miss fetches", w0 > 0, 1);

        // R6: hit served while port 0 waits on a fill
        h0 = stat_hit;
        fork
            issue(0, 0, 16'h0200, 0, w0);
            begin repeat (3) @(negedge clk); issue(1, 0, 16'h0047, 0, w1); end
        join
        chk("R6 hit under miss not stalled", w1, 0);
        chk("R6 hum and hit counts", {stat_hum, stat_hit}, {32'd1, h0 + 32'd1});

        // R5: a second miss during the fill waits for it
        f0 = fills_seen; m0 = stat_miss;
        fork
            issue(0, 0, 16'h0300, 0, w0);
            begin repeat (3) @(negedge clk); issue(1, 0, 16'h0401, 0, w1); end
        join
        chk("R5 second miss stalled past first fill", w1 > w0, 1);
        chk("R5 two fills two misses", {fills_seen - f0, stat_miss - m0}, {32'd2, 32'd2});

        // R8: same index, other tag evicts
        issue(0, 0, 16'h0840, 0, w0);
        f0 = fills_seen;
        issue(0, 0, 16'h0040, 0, w0);
        chk("R8 evicted line refetched", {fills_seen - f0, last_line}, {32'd1, 12'h004});

        // R9: access count matches accepted requests
        @(negedge clk); #1;
        chk("R9 access count", stat_access, acc_model);
        chk("R2 no extra conflicts", stat_conflict, 1);

        // R1: reset invalidates the cache
        rst = 1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 counters cleared", {stat_access, stat_miss, stat_hum}, '0);
        rst = 0;
        issue(0, 0, 16'h0040, 0, w0);
        chk("R1 line invalid after reset", w0 > 0, 1);
        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", exp_q0.size() + exp_q1.size(), 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule